// File: doc/BRIEF.md
# Micro-op precise interrupt restart

This block sits between an instruction decoder that cracks each instruction into a stream of up to eight micro-ops and the scheduler that issues them. Every micro-op arrives with its position in its instruction's stream. That position travels with the micro-op through each register stage, so an interrupt can land between two micro-ops of one instruction without first returning to an instruction boundary.

When an interrupt request meets a valid micro-op, that micro-op is replaced by an interrupt pseudo-op. The pseudo-op is marked valid and already complete, so the scheduler never issues it. The block also stores a fixed-point restart word. Its upper part is the instruction address with the two always-zero low bits dropped. Its lower three bits are the micro-op position. The two dropped address bits leave room for the position, so the restart word is one bit wider than the address.

After a return-from-interrupt strobe, the decoder reissues the interrupted instruction from position 0. The block turns every reissued micro-op below the saved position into a completed, non-writing NOP. The first micro-op that is not turned into a NOP closes this replay window. Faults found at decode are also marked complete at insertion and carry a cause code.

Top module: `uop_restart_unit`

## Requirements
- R1: A valid micro-op with no interrupt, fault or replay match leaves the block exactly STAGES (default 2) clock edges after it is presented. Its address, position, destination and write enable are unchanged, and its done, interrupt and fault flags and cause are 0.
- R2: When irq_req and dec_valid are both high in one cycle, that micro-op comes out as an interrupt pseudo-op. It has valid=1, done=1, irq flag=1, write enable=0 and cause 0, and it keeps its position.
- R3: On the clock edge that takes an interrupt, restart_word becomes {dec_pc[31:2], dec_idx[2:0]}, which is 33 bits with the position in bits 2:0.
- R4: resume_addr always equals {restart_word[32:3], 2'b00}.
- R5: irq_req while dec_valid is low has no effect: no micro-op is emitted and restart_word is unchanged. restart_word changes only when an interrupt is taken.
- R6: After rti_strobe is given while a restart is held, reissued micro-ops whose address equals resume_addr and whose position is below the saved position come out with valid=1, done=1 and write enable=0. They keep their position and destination.
- R7: The replay window closes on the first valid micro-op that is not converted. That micro-op and all later ones pass unchanged, including later micro-ops with a lower position.
- R8: A saved position of 0 converts nothing, so the whole instruction replays unchanged.
- R9: rti_strobe has no effect when no restart is held, that is after reset or after a replay window has closed.
- R10: A micro-op with dec_fault high (and no interrupt) comes out with done=1, fault flag=1, write enable=0 and its cause code.
- R11: After reset, out_valid is 0 and restart_word and resume_addr are 0.
- R12: An interrupt taken during a replay window wins over NOP conversion. The micro-op becomes an interrupt pseudo-op, and the restart word is saved again with the new position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoder micro-op present |
| dec_pc | input | AW | Address of the micro-op's instruction |
| dec_idx | input | IDXW | Position of the micro-op in its instruction's stream |
| dec_rd | input | RDW | Destination register |
| dec_wr_en | input | 1 | Micro-op writes its destination |
| dec_fault | input | 1 | Decode-time fault on this micro-op |
| dec_cause | input | CW | Fault cause code |
| irq_req | input | 1 | Interrupt request, taken on a valid micro-op |
| rti_strobe | input | 1 | Return from interrupt |
| out_valid | output | 1 | Micro-op to scheduler present |
| out_pc | output | AW | Instruction address |
| out_idx | output | IDXW | Micro-op position |
| out_rd | output | RDW | Destination register |
| out_wr_en | output | 1 | Register write allowed |
| out_done | output | 1 | Already complete, not to be issued |
| out_irq | output | 1 | Interrupt pseudo-op |
| out_fault | output | 1 | Decode-fault micro-op |
| out_cause | output | CW | Fault cause code |
| restart_word | output | AW-ZB+IDXW | Fixed-point restart point |
| resume_addr | output | AW | Instruction address rebuilt from restart_word |

## Verification
For every saved position from 0 to 7, the bench takes an interrupt at that position. It then replays all eight positions of the same instruction and expects NOPs strictly below the saved position. A wrong compare direction or an off-by-one boundary would therefore show at exactly one position. Other passes use handler micro-ops at another address while a restart is held, the next instruction and a same-address reissue after the window has closed, and a second return strobe with nothing held. These tell a window that closes correctly apart from one that stays open or reopens. Fault sweeps, an interrupt request with no micro-op, and an interrupt nested inside a replay separate the priority order interrupt over NOP over fault.

// File: rtl/upr_pkg.sv
package upr_pkg;

   // Restart tracking: nothing held, held awaiting return, replaying.
   typedef enum logic [1:0] {
      RS_IDLE   = 2'd0,
      RS_HELD   = 2'd1,
      RS_REPLAY = 2'd2
   } rs_state_e;

   // Control flags carried with each micro-op.
   typedef struct packed {
      logic valid;
      logic done;
      logic irq;
      logic fault;
      logic wr_en;
   } uop_ctl_t;

   localparam int CTL_W = $bits(uop_ctl_t);

endpackage

// File: rtl/upr_restart_reg.sv
module upr_restart_reg
   import upr_pkg::*;
#(
   parameter int AW   = 32,
   parameter int IDXW = 3,
   parameter int ZB   = 2,
   localparam int HI  = AW - ZB,
   localparam int RW  = HI + IDXW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_irq,
   input  logic [HI-1:0]   irq_pc_hi,
   input  logic [IDXW-1:0] irq_idx,
   input  logic            rti_strobe,
   input  logic            pass_real,
   output logic [RW-1:0]   restart_word,
   output logic [AW-1:0]   resume_addr,
   output logic [IDXW-1:0] saved_idx,
   output logic            replay_on
);

   rs_state_e state;
   logic [RW-1:0] word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= RS_IDLE;
         word_q <= '0;
      end else if (take_irq) begin
         word_q <= {irq_pc_hi, irq_idx};
         state  <= RS_HELD;
      end else begin
         unique case (state)
            RS_HELD:   if (rti_strobe) state <= RS_REPLAY;
            RS_REPLAY: if (pass_real)  state <= RS_IDLE;
            default:   state <= state;
         endcase
      end
   end

   assign restart_word = word_q;
   assign saved_idx    = word_q[IDXW-1:0];
   assign resume_addr  = {word_q[RW-1:IDXW], {ZB{1'b0}}};
   assign replay_on    = (state == RS_REPLAY);

endmodule

// File: rtl/upr_nop_filter.sv
module upr_nop_filter
   import upr_pkg::*;
#(
   parameter int AW         = 32,
   parameter int IDXW       = 3,
   parameter int CW         = 4,
   parameter bit MATCH_ADDR = 1'b1
) (
   input  logic            dec_valid,
   input  logic [AW-1:0]   dec_pc,
   input  logic [IDXW-1:0] dec_idx,
   input  logic            dec_wr_en,
   input  logic            dec_fault,
   input  logic [CW-1:0]   dec_cause,
   input  logic            irq_req,
   input  logic            replay_on,
   input  logic [AW-1:0]   resume_addr,
   input  logic [IDXW-1:0] saved_idx,
   output uop_ctl_t        ctl,
   output logic [CW-1:0]   cause,
   output logic            take_irq,
   output logic            pass_real
);

   logic addr_hit;
   logic convert;

   generate
      if (MATCH_ADDR) begin : g_match
         assign addr_hit = (dec_pc == resume_addr);
      end else begin : g_nomatch
         logic unused_pc;
         assign unused_pc = ^{dec_pc, resume_addr};
         assign addr_hit  = 1'b1;
      end
   endgenerate

   assign take_irq  = dec_valid & irq_req;
   assign convert   = dec_valid & replay_on & addr_hit & (dec_idx < saved_idx);
   assign pass_real = dec_valid & ~take_irq & ~convert;

   always_comb begin
      ctl.valid = dec_valid;
      ctl.done  = 1'b0;
      ctl.irq   = 1'b0;
      ctl.fault = 1'b0;
      ctl.wr_en = dec_valid & dec_wr_en;
      cause     = '0;
      if (take_irq) begin
         ctl.done  = 1'b1;
         ctl.irq   = 1'b1;
         ctl.wr_en = 1'b0;
      end else if (convert) begin
         ctl.done  = 1'b1;
         ctl.wr_en = 1'b0;
      end else if (dec_valid && dec_fault) begin
         ctl.done  = 1'b1;
         ctl.fault = 1'b1;
         ctl.wr_en = 1'b0;
         cause     = dec_cause;
      end
   end

endmodule

// File: rtl/upr_pipe_stage.sv
module upr_pipe_stage #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] d,
   output logic [PW-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/uop_restart_unit.sv
module uop_restart_unit
   import upr_pkg::*;
#(
   parameter int AW         = 32,
   parameter int IDXW       = 3,
   parameter int ZB         = 2,
   parameter int RDW        = 5,
   parameter int CW         = 4,
   parameter int STAGES     = 2,
   parameter bit MATCH_ADDR = 1'b1,
   localparam int RW        = AW - ZB + IDXW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dec_valid,
   input  logic [AW-1:0]   dec_pc,
   input  logic [IDXW-1:0] dec_idx,
   input  logic [RDW-1:0]  dec_rd,
   input  logic            dec_wr_en,
   input  logic            dec_fault,
   input  logic [CW-1:0]   dec_cause,
   input  logic            irq_req,
   input  logic            rti_strobe,
   output logic            out_valid,
   output logic [AW-1:0]   out_pc,
   output logic [IDXW-1:0] out_idx,
   output logic [RDW-1:0]  out_rd,
   output logic            out_wr_en,
   output logic            out_done,
   output logic            out_irq,
   output logic            out_fault,
   output logic [CW-1:0]   out_cause,
   output logic [RW-1:0]   restart_word,
   output logic [AW-1:0]   resume_addr
);

   localparam int PW = CTL_W + CW + RDW + IDXW + AW;

   generate
      if (IDXW <= ZB) begin : g_bad_idxw
         $error("IDXW must exceed ZB so the restart word grows past the address");
      end
      if (ZB < 1 || ZB >= AW) begin : g_bad_zb
         $error("ZB out of range");
      end
      if (STAGES < 1) begin : g_bad_stages
         $error("STAGES must be at least 1");
      end
   endgenerate

   uop_ctl_t        f_ctl;
   logic [CW-1:0]   f_cause;
   logic            take_irq;
   logic            pass_real;
   logic            replay_on;
   logic [IDXW-1:0] saved_idx;

   upr_restart_reg #(.AW(AW), .IDXW(IDXW), .ZB(ZB)) u_rreg (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_irq     (take_irq),
      .irq_pc_hi    (dec_pc[AW-1:ZB]),
      .irq_idx      (dec_idx),
      .rti_strobe   (rti_strobe),
      .pass_real    (pass_real),
      .restart_word (restart_word),
      .resume_addr  (resume_addr),
      .saved_idx    (saved_idx),
      .replay_on    (replay_on)
   );

   upr_nop_filter #(.AW(AW), .IDXW(IDXW), .CW(CW), .MATCH_ADDR(MATCH_ADDR)) u_filt (
      .dec_valid   (dec_valid),
      .dec_pc      (dec_pc),
      .dec_idx     (dec_idx),
      .dec_wr_en   (dec_wr_en),
      .dec_fault   (dec_fault),
      .dec_cause   (dec_cause),
      .irq_req     (irq_req),
      .replay_on   (replay_on),
      .resume_addr (resume_addr),
      .saved_idx   (saved_idx),
      .ctl         (f_ctl),
      .cause       (f_cause),
      .take_irq    (take_irq),
      .pass_real   (pass_real)
   );

   // Position, address and flags travel together through every stage.
   logic [PW-1:0] chain [STAGES+1];
   assign chain[0] = {f_ctl, f_cause, dec_rd, dec_idx, dec_pc};

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         upr_pipe_stage #(.PW(PW)) u_st (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (chain[g]),
            .q     (chain[g+1])
         );
      end
   endgenerate

   uop_ctl_t o_ctl;
   assign {o_ctl, out_cause, out_rd, out_idx, out_pc} = chain[STAGES];
   assign out_valid = o_ctl.valid;
   assign out_done  = o_ctl.done;
   assign out_irq   = o_ctl.irq;
   assign out_fault = o_ctl.fault;
   assign out_wr_en = o_ctl.wr_en;

endmodule

// File: rtl/upr_checker.sv
module upr_checker #(
   parameter int AW   = 32,
   parameter int IDXW = 3,
   parameter int ZB   = 2,
   localparam int HI  = AW - ZB,
   localparam int RW  = HI + IDXW
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dec_valid,
   input logic [HI-1:0]   dec_pc_hi,
   input logic [IDXW-1:0] dec_idx,
   input logic            irq_req,
   input logic            rti_strobe,
   input logic            out_valid,
   input logic            out_wr_en,
   input logic            out_done,
   input logic            out_irq,
   input logic            out_fault,
   input logic [RW-1:0]   restart_word,
   input logic [AW-1:0]   resume_addr,
   input logic            replay_on
);

   a_r2_irq_op_complete: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_irq) |-> (out_done && !out_wr_en && !out_fault));

   a_r10_fault_complete: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault) |-> (out_done && !out_wr_en));

   a_r3_restart_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && dec_valid) |=> (restart_word == {$past(dec_pc_hi), $past(dec_idx)}));

   a_r4_resume_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && dec_valid) |=> (resume_addr == {$past(dec_pc_hi), {ZB{1'b0}}}));

   a_r5_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_req && dec_valid) |=> $stable(restart_word));

   a_r6_replay_needs_rti: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(replay_on) |-> $past(rti_strobe));

endmodule

bind uop_restart_unit upr_checker #(.AW(AW), .IDXW(IDXW), .ZB(ZB)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dec_valid    (dec_valid),
   .dec_pc_hi    (dec_pc[AW-1:ZB]),
   .dec_idx      (dec_idx),
   .irq_req      (irq_req),
   .rti_strobe   (rti_strobe),
   .out_valid    (out_valid),
   .out_wr_en    (out_wr_en),
   .out_done     (out_done),
   .out_irq      (out_irq),
   .out_fault    (out_fault),
   .restart_word (restart_word),
   .resume_addr  (resume_addr),
   .replay_on    (replay_on)
);

// File: tb/uop_restart_unit_test.sv
`timescale 1ns/1ps
module uop_restart_unit_test;

   localparam int K_PASS  = 0;
   localparam int K_NOP   = 1;
   localparam int K_IRQ   = 2;
   localparam int K_FAULT = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dec_valid, dec_wr_en, dec_fault, irq_req, rti_strobe;
   logic [31:0] dec_pc;
   logic [2:0]  dec_idx;
   logic [4:0]  dec_rd;
   logic [3:0]  dec_cause;
   logic        out_valid, out_wr_en, out_done, out_irq, out_fault;
   logic [31:0] out_pc, resume_addr;
   logic [2:0]  out_idx;
   logic [4:0]  out_rd;
   logic [3:0]  out_cause;
   logic [32:0] restart_word;

   int n_chk  = 0;
   int n_fail = 0;

   typedef struct {
      logic [51:0] bits;
      string       req;
   } exp_t;
   exp_t expq[$];

   always #2 clk = ~clk;

   uop_restart_unit uut (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_pc(dec_pc),
      .dec_idx(dec_idx), .dec_rd(dec_rd), .dec_wr_en(dec_wr_en),
      .dec_fault(dec_fault), .dec_cause(dec_cause), .irq_req(irq_req),
      .rti_strobe(rti_strobe), .out_valid(out_valid), .out_pc(out_pc),
      .out_idx(out_idx), .out_rd(out_rd), .out_wr_en(out_wr_en),
      .out_done(out_done), .out_irq(out_irq), .out_fault(out_fault),
      .out_cause(out_cause), .restart_word(restart_word),
      .resume_addr(resume_addr)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Output monitor: every emitted micro-op is compared in order.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (expq.size() == 0) begin
            check("R5", "unexpected micro-op", 64'(out_idx), 64'hFFFF);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check(e.req, "micro-op fields",
                  64'({out_pc, out_idx, out_rd, out_done, out_irq,
                       out_fault, out_wr_en, out_cause}),
                  64'(e.bits));
         end
      end
   end

   task automatic issue(input logic v, input logic [31:0] pc,
                        input logic [2:0] idx, input logic flt,
                        input logic [3:0] cs, input logic irq,
                        input logic rti, input int kind, input string req);
      logic [4:0] rd;
      logic       wr;
      exp_t       e;
      rd = 5'd7 + {2'b00, idx};
      wr = ~idx[0];
      dec_valid = v; dec_pc = pc; dec_idx = idx; dec_rd = rd;
      dec_wr_en = wr; dec_fault = flt; dec_cause = cs;
      irq_req = irq; rti_strobe = rti;
      if (v) begin
         e.req  = req;
         e.bits = {pc, idx, rd,
                   kind != K_PASS, kind == K_IRQ, kind == K_FAULT,
                   (kind == K_PASS) ? wr : 1'b0,
                   (kind == K_FAULT) ? cs : 4'd0};
         expq.push_back(e);
      end
      @(negedge clk);
      dec_valid = 1'b0; dec_fault = 1'b0; irq_req = 1'b0; rti_strobe = 1'b0;
   endtask

   task automatic uop(input logic [31:0] pc, input logic [2:0] idx,
                      input int kind, input string req);
      issue(1'b1, pc, idx, 1'b0, 4'd0, kind == K_IRQ, 1'b0, kind, req);
   endtask

   task automatic rti();
      issue(1'b0, 32'd0, 3'd0, 1'b0, 4'd0, 1'b0, 1'b1, K_PASS, "R9");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      dec_valid = 1'b0; dec_pc = '0; dec_idx = '0; dec_rd = '0;
      dec_wr_en = 1'b0; dec_fault = 1'b0; dec_cause = '0;
      irq_req = 1'b0; rti_strobe = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      check("R11", "out_valid", 64'(out_valid), 64'd0);
      check("R11", "restart_word", 64'(restart_word), 64'd0);
      check("R11", "resume_addr", 64'(resume_addr), 64'd0);

      // R9: return strobe with nothing held, then all positions pass
      rti();
      for (int i = 0; i < 8; i++) uop(32'h0, 3'(i), K_PASS, "R9");

      // R1 latency: absent after one edge, present after the second
      repeat (3) @(negedge clk);
      uop(32'h1000, 3'd5, K_PASS, "R1");
      check("R1", "valid after 1 edge", 64'(out_valid), 64'd0);
      @(posedge clk); #1;
      check("R1", "valid after 2 edges", 64'(out_valid), 64'd1);
      check("R1", "index after 2 edges", 64'(out_idx), 64'd5);
      @(negedge clk);
      for (int i = 0; i < 8; i++) uop(32'h1100 + 32'(i*4), 3'(7 - i), K_PASS, "R1");

      // R10 decode faults with several causes
      for (int c = 0; c < 16; c += 3)
         issue(1'b1, 32'h1200, 3'(c % 8), 1'b1, 4'(c), 1'b0, 1'b0, K_FAULT, "R10");

      // R5: request with no micro-op present
      issue(1'b0, 32'h1300, 3'd4, 1'b0, 4'd0, 1'b1, 1'b0, K_PASS, "R5");
      repeat (3) @(negedge clk);
      check("R5", "restart_word", 64'(restart_word), 64'd0);
      check("R5", "out_valid", 64'(out_valid), 64'd0);

      // Sweep every saved position
      for (int s = 0; s < 8; s++) begin
         logic [31:0] pc;
         pc = 32'h2000 + 32'(s * 64);
         for (int i = 0; i < s; i++) uop(pc, 3'(i), K_PASS, "R1");
         uop(pc, 3'(s), K_IRQ, "R2");
         check("R3", "restart_word", 64'(restart_word), 64'({pc[31:2], 3'(s)}));
         check("R4", "resume_addr", 64'(resume_addr), 64'(pc));
         uop(32'h8000, 3'd0, K_PASS, "R6");
         uop(32'h8000, 3'd1, K_PASS, "R6");
         rti();
         for (int i = 0; i < 8; i++)
            uop(pc, 3'(i), (i < s) ? K_NOP : K_PASS, (s == 0) ? "R8" : "R6");
         for (int i = 0; i < 3; i++) uop(pc + 32'd4, 3'(i), K_PASS, "R7");
         uop(pc, 3'd0, K_PASS, "R7");
         rti();
         for (int i = 0; i < 8; i++) uop(pc, 3'(i), K_PASS, "R9");
      end

      // R12: interrupt inside a replay window
      for (int i = 0; i < 5; i++) uop(32'h3000, 3'(i), K_PASS, "R12");
      uop(32'h3000, 3'd5, K_IRQ, "R12");
      rti();
      uop(32'h3000, 3'd0, K_NOP, "R12");
      uop(32'h3000, 3'd1, K_NOP, "R12");
      uop(32'h3000, 3'd2, K_IRQ, "R12");
      check("R12", "restart_word", 64'(restart_word), 64'({30'h0C00, 3'd2}));
      rti();
      for (int i = 0; i < 8; i++) uop(32'h3000, 3'(i), (i < 2) ? K_NOP : K_PASS, "R12");

      repeat (5) @(negedge clk);
      check("R1", "pending micro-ops", 64'(expq.size()), 64'd0);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule